// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block takes one of three clocks, divides it by two independently selectable ratios, and fans each result out to a bank of identical outputs. Bank A divides by 2, 4, 6 or 8. Bank B divides by 4, 6, 8 or 12. Every ratio gives an exact 50% duty cycle. The source is either the internal oscillator clock or one of two reference clocks. A bypass select and a reference select choose between them.

An active-high master reset clears every divider counter and drops the output-enable signal. The pad ring uses that signal to float all eight pins. When the reset falls, the release is resynchronised to the selected source. Both banks then start together with a rising edge on the same source edge, so their rising edges coincide again every least-common-multiple of the two periods. A ratio change requested while running is held until that bank's next rising edge, which avoids runt pulses. The source mux is plain combinational logic. Source switches are expected only while the master reset is held or the clocks are quiet.

Top module: `clk_fanout_div`

## Requirements
- R1: With `osc_sel_i` high the dividers count `osc_clk_i` edges. With it low they count `ref_clk0_i` when `ref_sel_i` is 0 and `ref_clk1_i` when `ref_sel_i` is 1. Edges on an unselected clock have no effect.
- R2: Bank A select `div_sel_a_i` 00/01/10/11 gives division by 2/4/6/8. The output is high for exactly half the period, measured in source cycles.
- R3: Bank B select `div_sel_b_i` 00/01/10/11 gives division by 4/6/8/12. The output is high for exactly half the period.
- R4: All FANOUT outputs of a bank carry the same value at all times.
- R5: While `mr_i` is high, the outputs and the output enable are low and all divider state is cleared. This happens immediately, without waiting for a source edge.
- R6: After `mr_i` falls, `out_en_o` rises on the SYNC_STAGES-th selected source rising edge. Both banks rise on the following source edge.
- R7: From that first edge on, the rising edges of the two banks coincide every least-common-multiple of the two ratios.
- R8: A select change while running takes effect only at the bank's next rising edge. The period in progress finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Internal oscillator clock |
| ref_clk0_i | input | 1 | First reference clock |
| ref_clk1_i | input | 1 | Second reference clock |
| osc_sel_i | input | 1 | 1: oscillator feeds dividers; 0: chosen reference |
| ref_sel_i | input | 1 | 0: first reference, 1: second reference |
| mr_i | input | 1 | Active-high master reset and output disable |
| div_sel_a_i | input | 2 | Bank A ratio select |
| div_sel_b_i | input | 2 | Bank B ratio select |
| bank_a_o | output | FANOUT | Bank A divided clocks |
| bank_b_o | output | FANOUT | Bank B divided clocks |
| out_en_o | output | 1 | Pad enable; low means all outputs float |

## Verification
The hardest case to reach is a ratio change that lands part-way through a period. It must be deferred to the next rising edge and must not shorten the pulse in progress. The stimulus starts a bank at its slowest ratio, waits until the output is high, and then moves the select to the fastest ratio. The per-cycle reference model compares the result for 40 cycles. A second hard case is a clock that arrives on an unselected source. The bench toggles only the reference that the selects do not pick and confirms that the enable and the outputs stay low.

// File: rtl/clk_fanout_div_pkg.sv
package clk_fanout_div_pkg;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  typedef enum logic [1:0] {
    SEL_R0 = 2'd0,
    SEL_R1 = 2'd1,
    SEL_R2 = 2'd2,
    SEL_R3 = 2'd3
  } ratio_sel_e;

endpackage

// File: rtl/clk_src_mux.sv
module clk_src_mux (
  input  logic osc_clk_i,
  input  logic ref_clk0_i,
  input  logic ref_clk1_i,
  input  logic osc_sel_i,
  input  logic ref_sel_i,
  output logic src_clk_o
);
  logic ref_clk;

  assign ref_clk   = ref_sel_i ? ref_clk1_i : ref_clk0_i;
  assign src_clk_o = osc_sel_i ? osc_clk_i : ref_clk;
endmodule

// File: rtl/clk_run_sync.sv
module clk_run_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic run_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign run_o = sync_q[STAGES-1];
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
  import clk_fanout_div_pkg::*;
#(
  parameter int unsigned DIV0   = 2,
  parameter int unsigned DIV1   = 4,
  parameter int unsigned DIV2   = 6,
  parameter int unsigned DIV3   = 8,
  parameter int unsigned FANOUT = 4
) (
  input  logic              clk_i,
  input  logic              arst_n_i,
  input  logic              run_i,
  input  logic [1:0]        sel_i,
  output logic [FANOUT-1:0] q_o
);
  localparam int unsigned MAXD = max4(DIV0, DIV1, DIV2, DIV3);
  localparam int unsigned CW   = $clog2(MAXD / 2 + 1);

  function automatic logic [CW-1:0] half_of(input logic [1:0] s);
    case (ratio_sel_e'(s))
      SEL_R0:  return CW'(DIV0 / 2);
      SEL_R1:  return CW'(DIV1 / 2);
      SEL_R2:  return CW'(DIV2 / 2);
      default: return CW'(DIV3 / 2);
    endcase
  endfunction

  logic [1:0]    ratio_q, ratio_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;
  logic          wrap;

  assign wrap = (cnt_q == half_of(ratio_q) - CW'(1));

  always_comb begin
    ratio_d = ratio_q;
    cnt_d   = cnt_q;
    q_d     = q_q;
    if (!run_i) begin
      ratio_d = sel_i;
      cnt_d   = half_of(sel_i) - CW'(1);
      q_d     = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      q_d   = ~q_q;
      if (!q_q) ratio_d = sel_i;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      ratio_q <= '0;
      cnt_q   <= '0;
      q_q     <= 1'b0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      q_q     <= q_d;
    end
  end

  assign q_o = {FANOUT{q_q}};
endmodule

// File: rtl/clk_fanout_div.sv
module clk_fanout_div #(
  parameter int unsigned A_DIV0      = 2,
  parameter int unsigned A_DIV1      = 4,
  parameter int unsigned A_DIV2      = 6,
  parameter int unsigned A_DIV3      = 8,
  parameter int unsigned B_DIV0      = 4,
  parameter int unsigned B_DIV1      = 6,
  parameter int unsigned B_DIV2      = 8,
  parameter int unsigned B_DIV3      = 12,
  parameter int unsigned FANOUT      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              osc_clk_i,
  input  logic              ref_clk0_i,
  input  logic              ref_clk1_i,
  input  logic              osc_sel_i,
  input  logic              ref_sel_i,
  input  logic              mr_i,
  input  logic [1:0]        div_sel_a_i,
  input  logic [1:0]        div_sel_b_i,
  output logic [FANOUT-1:0] bank_a_o,
  output logic [FANOUT-1:0] bank_b_o,
  output logic              out_en_o
);
  logic src_clk;
  logic arst_n;
  logic run;

  assign arst_n = ~mr_i;

  clk_src_mux u_src (
    .osc_clk_i (osc_clk_i),
    .ref_clk0_i(ref_clk0_i),
    .ref_clk1_i(ref_clk1_i),
    .osc_sel_i (osc_sel_i),
    .ref_sel_i (ref_sel_i),
    .src_clk_o (src_clk)
  );

  clk_run_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (src_clk),
    .arst_n_i(arst_n),
    .run_o   (run)
  );

  clk_div_bank #(
    .DIV0(A_DIV0), .DIV1(A_DIV1), .DIV2(A_DIV2), .DIV3(A_DIV3), .FANOUT(FANOUT)
  ) u_bank_a (
    .clk_i   (src_clk),
    .arst_n_i(arst_n),
    .run_i   (run),
    .sel_i   (div_sel_a_i),
    .q_o     (bank_a_o)
  );

  clk_div_bank #(
    .DIV0(B_DIV0), .DIV1(B_DIV1), .DIV2(B_DIV2), .DIV3(B_DIV3), .FANOUT(FANOUT)
  ) u_bank_b (
    .clk_i   (src_clk),
    .arst_n_i(arst_n),
    .run_i   (run),
    .sel_i   (div_sel_b_i),
    .q_o     (bank_b_o)
  );

  assign out_en_o = run;
endmodule

// File: rtl/clk_fanout_div_chk.sv
module clk_fanout_div_chk #(
  parameter int unsigned A_DIV0 = 2,
  parameter int unsigned A_DIV1 = 4,
  parameter int unsigned A_DIV2 = 6,
  parameter int unsigned A_DIV3 = 8,
  parameter int unsigned B_DIV0 = 4,
  parameter int unsigned B_DIV1 = 6,
  parameter int unsigned B_DIV2 = 8,
  parameter int unsigned B_DIV3 = 12,
  parameter int unsigned FANOUT = 4
) (
  input logic              src_clk,
  input logic              mr_i,
  input logic              out_en_o,
  input logic [FANOUT-1:0] bank_a_o,
  input logic [FANOUT-1:0] bank_b_o
);
  logic       prev_a, prev_b, seen_a, seen_b;
  logic [7:0] per_a, per_b;
  logic       rise_a, rise_b;

  assign rise_a = bank_a_o[0] && !prev_a;
  assign rise_b = bank_b_o[0] && !prev_b;

  always_ff @(posedge src_clk or posedge mr_i) begin
    if (mr_i) begin
      prev_a <= 1'b0; prev_b <= 1'b0;
      seen_a <= 1'b0; seen_b <= 1'b0;
      per_a  <= '0;   per_b  <= '0;
    end else begin
      prev_a <= bank_a_o[0];
      prev_b <= bank_b_o[0];
      if (rise_a) begin per_a <= 8'd1; seen_a <= 1'b1; end
      else if (per_a != 8'hFF) per_a <= per_a + 8'd1;
      if (rise_b) begin per_b <= 8'd1; seen_b <= 1'b1; end
      else if (per_b != 8'hFF) per_b <= per_b + 8'd1;
    end
  end

  always @(posedge src_clk) begin
    if (!mr_i && rise_a && seen_a)
      AST_A_PERIOD_LEGAL: assert (per_a == 8'(A_DIV0) || per_a == 8'(A_DIV1) || per_a == 8'(A_DIV2) || per_a == 8'(A_DIV3)); // R2
    if (!mr_i && rise_b && seen_b)
      AST_B_PERIOD_LEGAL: assert (per_b == 8'(B_DIV0) || per_b == 8'(B_DIV1) || per_b == 8'(B_DIV2) || per_b == 8'(B_DIV3)); // R3
    AST_A_FANOUT_EQUAL: assert (bank_a_o == {FANOUT{bank_a_o[0]}}); // R4
    AST_B_FANOUT_EQUAL: assert (bank_b_o == {FANOUT{bank_b_o[0]}}); // R4
    if (mr_i)
      AST_RESET_QUIET: assert (!out_en_o && bank_a_o == '0 && bank_b_o == '0); // R5
  end

  AST_DISABLED_LOW: assert property (@(posedge src_clk) disable iff (mr_i)
    !out_en_o |-> (bank_a_o == '0 && bank_b_o == '0)); // R5

  AST_START_TOGETHER: assert property (@(posedge src_clk) disable iff (mr_i)
    $rose(out_en_o) |=> (bank_a_o[0] && bank_b_o[0])); // R6
endmodule

bind clk_fanout_div clk_fanout_div_chk #(
  .A_DIV0(A_DIV0), .A_DIV1(A_DIV1), .A_DIV2(A_DIV2), .A_DIV3(A_DIV3),
  .B_DIV0(B_DIV0), .B_DIV1(B_DIV1), .B_DIV2(B_DIV2), .B_DIV3(B_DIV3),
  .FANOUT(FANOUT)
) u_chk (
  .src_clk (src_clk),
  .mr_i    (mr_i),
  .out_en_o(out_en_o),
  .bank_a_o(bank_a_o),
  .bank_b_o(bank_b_o)
);

// File: tb/clk_fanout_div_tb.sv
module clk_fanout_div_tb;
  localparam int STG = 2;
  localparam int FO  = 4;
  // undriven-pin defaults: selects and reset low, bypass select high
  localparam logic DEF_OSC_SEL = 1'b1;
  localparam logic DEF_LOW     = 1'b0;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int drv;  // which clock input carries the toggling clock: 0 osc, 1 ref0, 2 ref1
  logic osc_sel, ref_sel, mr;
  logic [1:0] sa, sb;
  logic [FO-1:0] qa_o, qb_o;
  logic en_o;
  logic osc_clk, ref0, ref1;

  assign osc_clk = clk && (drv == 0);
  assign ref0    = clk && (drv == 1);
  assign ref1    = clk && (drv == 2);

  clk_fanout_div u_dut (
    .osc_clk_i(osc_clk), .ref_clk0_i(ref0), .ref_clk1_i(ref1),
    .osc_sel_i(osc_sel), .ref_sel_i(ref_sel), .mr_i(mr),
    .div_sel_a_i(sa), .div_sel_b_i(sb),
    .bank_a_o(qa_o), .bank_b_o(qb_o), .out_en_o(en_o)
  );

  int n_chk = 0, n_fail = 0;
  string tag_a = "R2", tag_b = "R3", tag_en = "R6";

  function automatic int div_a(input logic [1:0] s);
    return 2 * (int'(s) + 1);
  endfunction
  function automatic int div_b(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 6;
      2'd2: return 8;
      default: return 12;
    endcase
  endfunction

  // behavioural reference model
  int rel = 0, na = 2, nb = 4, pa = 0, pb = 0;
  logic ea = 1'b0, eb = 1'b0;

  always @(posedge clk) begin
    int want;
    want = osc_sel ? 0 : (ref_sel ? 2 : 1);
    if (mr) begin
      rel = 0; ea = 1'b0; eb = 1'b0;
    end else if (drv == want) begin
      if (rel < STG + 2) rel++;
      if (rel == STG + 1) begin
        na = div_a(sa); nb = div_b(sb); pa = 0; pb = 0; ea = 1'b1; eb = 1'b1;
      end else if (rel > STG + 1) begin
        pa++;
        if (pa == na) begin pa = 0; na = div_a(sa); ea = 1'b1; end
        else ea = (pa < na / 2);
        pb++;
        if (pb == nb) begin pb = 0; nb = div_b(sb); eb = 1'b1; end
        else eb = (pb < nb / 2);
      end
    end
  end

  task automatic check_bits(input string req, input logic [FO-1:0] act, input logic [FO-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_bits(tag_a, qa_o, {FO{ea}});
      check_bits(tag_b, qb_o, {FO{eb}});
      check_bits(tag_en, {3'b000, en_o}, {3'b000, (!mr && rel >= STG)});
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    drv = 0; osc_sel = DEF_OSC_SEL; ref_sel = DEF_LOW; mr = 1'b1;
    sa = {2{DEF_LOW}}; sb = {2{DEF_LOW}};
    tag_a = "R5"; tag_b = "R5"; tag_en = "R5";
    tick(3);  // reset state

    // R2 R3 R6 R1: all 16 select pairs, rotating the source
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      mr = 1'b1;
      sa = 2'(c / 4); sb = 2'(c % 4);
      case (c % 3)
        0: begin drv = 0; osc_sel = 1'b1; ref_sel = 1'b0; end
        1: begin drv = 1; osc_sel = 1'b0; ref_sel = 1'b0; end
        default: begin drv = 2; osc_sel = 1'b0; ref_sel = 1'b1; end
      endcase
      tag_a = "R2 R4"; tag_b = "R3 R4"; tag_en = "R6 R1";
      tick(1);
      mr = 1'b0;
      tick(30);
    end

    // R1: clock only on the unselected reference -> nothing happens
    mr = 1'b1;
    tick(1);
    drv = 2; osc_sel = 1'b0; ref_sel = 1'b0; sa = 2'd0; sb = 2'd0;
    tag_a = "R1"; tag_b = "R1"; tag_en = "R1";
    tick(1);
    mr = 1'b0;
    tick(20);

    // R7: ratios 4 and 6 line up every 12 cycles
    mr = 1'b1; drv = 1;
    tick(1);
    sa = 2'd1; sb = 2'd1;
    tag_a = "R7"; tag_b = "R7"; tag_en = "R7";
    mr = 1'b0;
    tick(40);

    // R8: change ratio mid-period
    mr = 1'b1; drv = 0; osc_sel = 1'b1;
    tick(1);
    sa = 2'd3; sb = 2'd3;
    tag_a = "R8"; tag_b = "R8"; tag_en = "R8";
    mr = 1'b0;
    tick(STG + 3);
    sa = 2'd0; sb = 2'd0;
    tick(40);
    sa = 2'd2; sb = 2'd2;
    tick(7);
    sa = 2'd1; sb = 2'd3;
    tick(40);

    // R5: asynchronous master reset while running
    tag_a = "R5"; tag_b = "R5"; tag_en = "R5";
    mr = 1'b1;
    #1;
    check_bits("R5", {qa_o[1:0], qb_o[1:0]}, 4'b0000);
    check_bits("R5", {3'b000, en_o}, 4'b0000);
    tick(4);
    mr = 1'b0;
    tick(20);

    finish_run();
  end
endmodule